// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a write-mostly slave on a shared two-wire bus. The data line is open-drain. Both bus lines are oversampled on a faster system clock. Each line passes through a two-flop synchronizer, and line edges, start conditions and stop conditions are decoded on the system clock. A transfer begins with a start condition and an address byte. The address byte carries a fixed 7-bit device address and a direction bit. When the address matches, the slave acknowledges every byte that follows.

A write transfer carries an address byte, then two filler bytes, then the configuration bytes. The slave acknowledges the filler bytes and throws their contents away. It stores up to three configuration bytes, in arrival order, in registers that drive a parallel output bus; the third byte is reserved for future use. Bytes that arrive after the last register are acknowledged and dropped. A read transfer is acknowledged at the address byte. After that the slave keeps the data line released and returns no contents. The slave ignores traffic that carries a foreign address until the next start condition.

The data output is an enable for an open-drain pull-down: high means drive the line low, low means release it.

Top module: `twoWireCfgSlave`

## Requirements
- R1: After reset the data line is released (`sdaDrvLow` = 0) and every configuration byte on `cfgData` is 0x00.
- R2: An address byte equal to 1100101 followed by direction bit 0 (byte value 0xCA, MSB first) is acknowledged by holding `sdaDrvLow` high during the ninth serial clock high phase.
- R3: An address byte with any other 7-bit address is not acknowledged. Every later byte up to the next start is also not acknowledged, and the stored registers do not change.
- R4: The two bytes that follow a write address are acknowledged, and neither changes `cfgData`.
- R5: The third, fourth and fifth bytes after a write address are stored in order as Data0 in `cfgData[7:0]`, Data1 in `cfgData[15:8]` and Data2 in `cfgData[23:16]`. Each byte is received MSB first and acknowledged.
- R6: Bytes after the fifth byte of a write transfer are acknowledged and leave `cfgData` unchanged.
- R7: An address byte of 1100101 with direction bit 1 (0xCB) is acknowledged. The data line then stays released through every later bit and acknowledge slot until the next start or stop.
- R8: A repeated start in the middle of a transfer restarts the address phase, and the filler/data byte count starts again from the address byte.
- R9: A stop returns the slave to idle with `cfgData` unchanged. Bytes clocked after a stop without a new start are neither acknowledged nor stored.
- R10: The slave drives the data line only in the acknowledge slot. The drive begins after the serial clock falls at the end of the eighth bit and ends after the next serial clock fall, so it is released through all eight data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the bus lines |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen at the pad |
| sdaIn | input | 1 | Serial data line as seen at the pad (resolved wired-AND level) |
| sdaDrvLow | output | 1 | Open-drain enable: 1 pulls the data line low, 0 releases it |
| cfgData | output | 8*DATA_BYTES (24) | Stored configuration bytes, Data0 in the low byte |

## Verification
On every cycle, the embedded properties check the acknowledge drive. It may begin only after a detected serial clock fall. It may end only on a clock fall, a start or a stop. It must be absent just after a stop and in the ignore state. They also check that a register load happens only when a full byte has been shifted in. Other behaviours can only be shown by the bench's scenarios. These are which bytes count as filler, which land in which register, and that extra bytes, foreign addresses and read transfers leave the registers untouched. The same goes for a repeated start resetting the byte count.

// File: rtl/twcPkg.sv
package twcPkg;
  localparam int CFG_SEL_W = 4;

  typedef struct packed {
    logic                 shiftEn;
    logic                 clearBits;
    logic                 loadReg;
    logic [CFG_SEL_W-1:0] regSel;
  } twcStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK,
    ST_IGNORE
  } twcState_t;
endpackage

// File: rtl/twcDatapath.sv
module twcDatapath
  import twcPkg::*;
#(
  parameter int DATA_BYTES = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sclIn,
  input  logic                    sdaIn,
  input  twcStrobes_t             ctl,
  output logic                    sclFall,
  output logic                    startSeen,
  output logic                    stopSeen,
  output logic                    byteFull,
  output logic [7:0]              shiftByte,
  output logic [8*DATA_BYTES-1:0] cfgData
);
  logic [1:0] sclSync, sdaSync;
  logic       sclD, sdaD, sclS, sdaS, sclRise;
  logic [3:0] bitCnt;

  // two-flop synchronizers plus one delay stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclD    <= sclSync[1];
      sdaD    <= sdaSync[1];
    end
  end

  assign sclS      = sclSync[1];
  assign sdaS      = sdaSync[1];
  assign sclRise   = sclS & ~sclD;
  assign sclFall   = ~sclS & sclD;
  assign startSeen = sclS & sclD & sdaD & ~sdaS;
  assign stopSeen  = sclS & sclD & ~sdaD & sdaS;
  assign byteFull  = (bitCnt == 4'd8);

  // serial-in shift register, MSB arrives first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt    <= '0;
      shiftByte <= '0;
    end else if (ctl.clearBits) begin
      bitCnt <= '0;
    end else if (ctl.shiftEn && sclRise && !byteFull) begin
      shiftByte <= {shiftByte[6:0], sdaS};
      bitCnt    <= bitCnt + 4'd1;
    end
  end

  // one register per stored configuration byte
  for (genvar k = 0; k < DATA_BYTES; k++) begin : g_cfgReg
    logic [7:0] regQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regQ <= '0;
      else if (ctl.loadReg && ctl.regSel == CFG_SEL_W'(k))
        regQ <= shiftByte;
    end
    assign cfgData[8*k +: 8] = regQ;
  end

  // R5: a register is written only from a completely received byte
  p_load_needs_full_byte_r5 : assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadReg |-> byteFull);

  // R10: the bit counter never runs past one byte
  p_bit_count_bounded_r10 : assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= 4'd8);
endmodule

// File: rtl/twcControl.sv
module twcControl
  import twcPkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1100101,
  parameter int         DUMMY_BYTES = 2,
  parameter int         DATA_BYTES  = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclFall,
  input  logic        startSeen,
  input  logic        stopSeen,
  input  logic        byteFull,
  input  logic [7:0]  shiftByte,
  output twcStrobes_t ctl,
  output logic        sdaDrvLow
);
  localparam int IDX_W = $clog2(DUMMY_BYTES + DATA_BYTES + 2);
  localparam logic [IDX_W-1:0] FIRST_IDX = IDX_W'(1 + DUMMY_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(DUMMY_BYTES + DATA_BYTES);
  localparam logic [IDX_W-1:0] SAT_IDX   = IDX_W'(DUMMY_BYTES + DATA_BYTES + 1);

  twcState_t        state;
  logic [IDX_W-1:0] byteIdx;
  logic             isRead, ackDrive;
  logic             byteDone, addrHit, inData;

  always_comb begin
    byteDone      = (state == ST_RECV) && sclFall && byteFull;
    addrHit       = (shiftByte[7:1] == DEV_ADDR);
    inData        = (byteIdx >= FIRST_IDX) && (byteIdx <= LAST_IDX);
    ctl.shiftEn   = (state == ST_RECV);
    ctl.clearBits = startSeen || byteDone;
    ctl.loadReg   = byteDone && inData;
    ctl.regSel    = CFG_SEL_W'(byteIdx - FIRST_IDX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      byteIdx  <= '0;
      isRead   <= 1'b0;
      ackDrive <= 1'b0;
    end else if (startSeen) begin
      state    <= ST_RECV;
      byteIdx  <= '0;
      isRead   <= 1'b0;
      ackDrive <= 1'b0;
    end else if (stopSeen) begin
      state    <= ST_IDLE;
      ackDrive <= 1'b0;
    end else begin
      case (state)
        ST_RECV: if (byteDone) begin
          if (byteIdx == '0) begin
            if (addrHit) begin
              ackDrive <= 1'b1;
              isRead   <= shiftByte[0];
              state    <= ST_ACK;
            end else begin
              state <= ST_IGNORE;
            end
          end else begin
            ackDrive <= 1'b1;
            state    <= ST_ACK;
          end
        end
        ST_ACK: if (sclFall) begin
          ackDrive <= 1'b0;
          state    <= isRead ? ST_IGNORE : ST_RECV;
          if (byteIdx != SAT_IDX) byteIdx <= byteIdx + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign sdaDrvLow = ackDrive;

  // R2: the acknowledge drive starts only after a detected clock fall
  p_ack_starts_on_fall_r2 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDrvLow) |-> $past(sclFall));

  // R10: the drive ends only on a clock fall or a bus condition
  p_ack_ends_on_event_r10 : assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaDrvLow) |-> $past(sclFall || startSeen || stopSeen));

  // R3: silent while ignoring foreign or read traffic
  p_silent_when_ignoring_r3 : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE) |-> !sdaDrvLow);

  // R9: a stop always leaves the line released
  p_stop_releases_r9 : assert property (@(posedge clk) disable iff (!rstN)
    $past(stopSeen) |-> !sdaDrvLow);
endmodule

// File: rtl/twoWireCfgSlave.sv
module twoWireCfgSlave
  import twcPkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1100101,
  parameter int         DUMMY_BYTES = 2,
  parameter int         DATA_BYTES  = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sclIn,
  input  logic                    sdaIn,
  output logic                    sdaDrvLow,
  output logic [8*DATA_BYTES-1:0] cfgData
);
  twcStrobes_t ctl;
  logic        sclFall, startSeen, stopSeen, byteFull;
  logic [7:0]  shiftByte;

  twcDatapath #(.DATA_BYTES(DATA_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ctl(ctl),
    .sclFall(sclFall), .startSeen(startSeen), .stopSeen(stopSeen),
    .byteFull(byteFull), .shiftByte(shiftByte), .cfgData(cfgData)
  );

  twcControl #(.DEV_ADDR(DEV_ADDR), .DUMMY_BYTES(DUMMY_BYTES), .DATA_BYTES(DATA_BYTES)) u_ctl (
    .clk(clk), .rstN(rstN), .sclFall(sclFall), .startSeen(startSeen),
    .stopSeen(stopSeen), .byteFull(byteFull), .shiftByte(shiftByte),
    .ctl(ctl), .sdaDrvLow(sdaDrvLow)
  );
endmodule

// File: tb/tb_twoWireCfgSlave.sv
module tb_twoWireCfgSlave;
  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        masterScl = 1'b1;
  logic        masterSda = 1'b1;
  logic        sdaLine;
  logic        sdaDrvLow;
  logic [23:0] cfgData;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic  expVal[$];
  string expReq[$];
  event  ackEv;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sdaLine = masterSda & ~sdaDrvLow;

  twoWireCfgSlave dut (
    .clk(clk), .rstN(rstN), .sclIn(masterScl), .sdaIn(sdaLine),
    .sdaDrvLow(sdaDrvLow), .cfgData(cfgData)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic busStart();
    masterSda = 1'b1; waitQ();
    masterScl = 1'b1; waitQ();
    masterSda = 1'b0; waitQ();
    masterScl = 1'b0;
  endtask

  task automatic busStop();
    masterSda = 1'b0; waitQ();
    masterScl = 1'b1; waitQ();
    masterSda = 1'b1; waitQ();
  endtask

  // driver: eight bits, then the acknowledge slot; expectation goes to the scoreboard
  task automatic sendByte(input logic [7:0] b, input logic ackExp, input string ackReq, input string bitReq);
    int driven = 0;
    for (int i = 7; i >= 0; i--) begin
      waitQ(); masterSda = b[i];
      waitQ(); masterScl = 1'b1;
      waitQ(); if (sdaDrvLow) driven++;
      waitQ(); masterScl = 1'b0;
    end
    check(driven == 0, bitReq, driven, 0);
    waitQ(); masterSda = 1'b1;
    waitQ(); masterScl = 1'b1;
    waitQ();
    expVal.push_back(ackExp);
    expReq.push_back(ackReq);
    -> ackEv;
    waitQ(); masterScl = 1'b0;
  endtask

  // monitor: compares the acknowledge slot against the queued expectation
  initial begin
    forever begin
      @(ackEv);
      if (expVal.size() != 0) begin
        logic  e;
        string r;
        e = expVal.pop_front();
        r = expReq.pop_front();
        check(sdaDrvLow == e, r, sdaDrvLow, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sdaDrvLow == 1'b0, "R1", sdaDrvLow, 0);
    check(cfgData == 24'h0, "R1", cfgData, 0);

    // full write: address, two fillers, three data, one extra
    busStart();
    sendByte(8'hCA, 1'b1, "R2", "R10");
    sendByte(8'hAA, 1'b1, "R4", "R10");
    sendByte(8'h55, 1'b1, "R4", "R10");
    check(cfgData == 24'h0, "R4", cfgData, 0);
    sendByte(8'h11, 1'b1, "R5", "R10");
    check(cfgData == 24'h000011, "R5", cfgData, 24'h000011);
    sendByte(8'h22, 1'b1, "R5", "R10");
    sendByte(8'h33, 1'b1, "R5", "R10");
    check(cfgData == 24'h332211, "R5", cfgData, 24'h332211);
    sendByte(8'h44, 1'b1, "R6", "R10");
    sendByte(8'h66, 1'b1, "R6", "R10");
    check(cfgData == 24'h332211, "R6", cfgData, 24'h332211);
    busStop();
    check(cfgData == 24'h332211, "R9", cfgData, 24'h332211);

    // foreign address
    busStart();
    sendByte(8'hC8, 1'b0, "R3", "R3");
    for (int n = 0; n < 5; n++) sendByte(8'h77 + 8'(n), 1'b0, "R3", "R3");
    busStop();
    check(cfgData == 24'h332211, "R3", cfgData, 24'h332211);

    // read transfer: acknowledged, then the line stays released
    busStart();
    sendByte(8'hCB, 1'b1, "R7", "R10");
    sendByte(8'hFF, 1'b0, "R7", "R7");
    sendByte(8'hFF, 1'b0, "R7", "R7");
    busStop();
    check(cfgData == 24'h332211, "R7", cfgData, 24'h332211);

    // repeated start in the middle of the filler bytes
    busStart();
    sendByte(8'hCA, 1'b1, "R8", "R10");
    sendByte(8'h99, 1'b1, "R8", "R10");
    busStart();
    sendByte(8'hCA, 1'b1, "R8", "R10");
    sendByte(8'h01, 1'b1, "R8", "R10");
    sendByte(8'h02, 1'b1, "R8", "R10");
    check(cfgData == 24'h332211, "R8", cfgData, 24'h332211);
    sendByte(8'hA1, 1'b1, "R8", "R10");
    sendByte(8'hB2, 1'b1, "R8", "R10");
    check(cfgData == 24'h33B2A1, "R8", cfgData, 24'h33B2A1);
    busStop();

    // bytes after a stop without a new start
    sendByte(8'hCA, 1'b0, "R9", "R9");
    sendByte(8'h5A, 1'b0, "R9", "R9");
    check(cfgData == 24'h33B2A1, "R9", cfgData, 24'h33B2A1);
    masterScl = 1'b1; waitQ();
    check(sdaDrvLow == 1'b0, "R9", sdaDrvLow, 0);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule